// File: doc/BRIEF.md
# Broadcast-Input Systolic FIR Array

This block is a three-tap finite impulse response filter built from a short chain of identical multiply-accumulate elements. Every accepted input sample is presented to all three elements in the same clock cycle. Each element keeps one coefficient in a local register. The partial sums flow from element to element through exactly one register per hop. The element that holds the oldest tap starts the chain from zero. The element that holds the newest tap produces the filter output, so the chain has the transposed structure and its hardware utilization is full: each element does one useful multiply-accumulate per accepted sample.

Samples arrive on a stream with a valid strobe. The chain advances only on cycles where that strobe is high, so gaps in the stream do not disturb the result. Coefficients are written through a small address-selected port, which may be used while samples are flowing. The result leaves on a stream with its own valid strobe, one cycle after each accepted sample. Arithmetic is signed two's complement, and the result is kept at full precision with no saturation.

Top module: `bcast_fir_array`

## Requirements
- R1: For accepted samples x(n), the output is y(n) = w0·x(n) + w1·x(n−1) + w2·x(n−2). Data and coefficients are signed DATA_W-bit values, and y is signed and 2·DATA_W+2 bits wide.
- R2: resultValid is high in the cycle after an edge at which sampleValid was high, and low otherwise. resultData carries y(n) for that sample while resultValid is high.
- R3: After reset, the samples before the first accepted sample count as zero.
- R4: An edge with sampleValid low changes nothing. resultData holds its value, and the accepted samples are filtered as if they had arrived back to back.
- R5: A write with coefWrite high and coefAddr equal to 0, 1 or 2 loads coefData into w0, w1 or w2 at that edge. It affects only samples accepted at later edges. A sample accepted at the same edge as the write uses the old value.
- R6: When coefficients change while samples are flowing, the term wk·x(n−k) uses the value of wk that was in force when sample n−k was accepted.
- R7: A write with coefAddr equal to 3 changes no coefficient.
- R8: A synchronous active-high reset clears all three coefficients, all partial sums, resultData and resultValid to zero.
- R9: Full-scale operands do not overflow. With all coefficients and samples at −2^(DATA_W−1), the output is 3·2^(2·DATA_W−2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | The sample on sampleData is accepted at this edge |
| sampleData | input | DATA_W | Signed input sample, broadcast to all elements |
| coefWrite | input | 1 | Coefficient write strobe |
| coefAddr | input | 2 | Tap select: 0 = w0, 1 = w1, 2 = w2, 3 = no target |
| coefData | input | DATA_W | Signed coefficient value to load |
| resultValid | output | 1 | resultData holds a new filter output |
| resultData | output | 2·DATA_W+2 | Signed filter output y(n) |

## Verification
An impulse exposes each coefficient separately at its own lag, which shows that the chain order and the one-register hops are right. A step shows that the running sums accumulate, and full-scale negative operands show that the result is wide enough and correctly signed. Streams with irregular idle gaps separate advancing on accepted samples from advancing on every clock. Coefficient writes made mid-stream, including writes in the same cycle as a sample, pin down which coefficient each product uses. A long pseudo-random sweep over several coefficient sets is compared against a convolution computed in the bench from per-sample coefficient snapshots.

// File: rtl/bfa_pkg.sv
package bfa_pkg;
  // number of filter taps (elements in the chain)
  localparam int TAPS = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic            advance;  // accept a sample at this edge
    logic [TAPS-1:0] loadSel;  // one-hot coefficient load select
  } bfaStrobes_t;
endpackage

// File: rtl/bfa_ctrl.sv
module bfa_ctrl
  import bfa_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleValid,
  input  logic              coefWrite,
  input  logic [ADDR_W-1:0] coefAddr,
  output bfaStrobes_t       strobes,
  output logic              resultValid
);
  logic [TAPS-1:0] selDecode;

  // address decode; codes at or above TAPS have no target
  for (genvar k = 0; k < TAPS; k++) begin : g_dec
    assign selDecode[k] = coefWrite && (coefAddr == ADDR_W'(k));
  end

  assign strobes.advance = sampleValid;
  assign strobes.loadSel = selDecode;

  // output valid trails the accepted sample by the single chain register
  always_ff @(posedge clk) begin
    if (rst) resultValid <= 1'b0;
    else     resultValid <= sampleValid;
  end
endmodule

// File: rtl/bfa_pe.sv
module bfa_pe #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 2 * DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     advance,
  input  logic                     loadEn,
  input  logic signed [DATA_W-1:0] coefIn,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic signed [ACC_W-1:0]  sumIn,
  output logic signed [ACC_W-1:0]  sumOut
);
  localparam int PROD_W = 2 * DATA_W;

  logic signed [DATA_W-1:0] coefReg;
  logic signed [PROD_W-1:0] product;
  logic signed [ACC_W-1:0]  productExt;
  logic signed [ACC_W-1:0]  macValue;

  assign product    = coefReg * sampleIn;
  assign productExt = {{(ACC_W - PROD_W){product[PROD_W-1]}}, product};
  assign macValue   = productExt + sumIn;

  // resident coefficient
  always_ff @(posedge clk) begin
    if (rst)         coefReg <= '0;
    else if (loadEn) coefReg <= coefIn;
  end

  // one register per hop for the moving partial sum
  always_ff @(posedge clk) begin
    if (rst)          sumOut <= '0;
    else if (advance) sumOut <= macValue;
  end
endmodule

// File: rtl/bfa_datapath.sv
module bfa_datapath
  import bfa_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 2 * DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  bfaStrobes_t              strobes,
  input  logic signed [DATA_W-1:0] sampleData,
  input  logic signed [DATA_W-1:0] coefData,
  output logic signed [ACC_W-1:0]  resultData
);
  // sumChain[k] is the output of the element holding tap k
  logic signed [ACC_W-1:0] sumChain [TAPS+1];

  // the element holding the oldest tap starts from zero
  assign sumChain[TAPS] = '0;

  for (genvar k = 0; k < TAPS; k++) begin : g_pe
    bfa_pe #(
      .DATA_W(DATA_W),
      .ACC_W (ACC_W)
    ) pe_i (
      .clk     (clk),
      .rst     (rst),
      .advance (strobes.advance),
      .loadEn  (strobes.loadSel[k]),
      .coefIn  (coefData),
      .sampleIn(sampleData),
      .sumIn   (sumChain[k+1]),
      .sumOut  (sumChain[k])
    );
  end

  assign resultData = sumChain[0];
endmodule

// File: rtl/bcast_fir_array.sv
module bcast_fir_array
  import bfa_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            sampleValid,
  input  logic signed [DATA_W-1:0]        sampleData,
  input  logic                            coefWrite,
  input  logic [ADDR_W-1:0]               coefAddr,
  input  logic signed [DATA_W-1:0]        coefData,
  output logic                            resultValid,
  output logic signed [2*DATA_W+1:0]      resultData
);
  localparam int ACC_W = 2 * DATA_W + 2;

  bfaStrobes_t strobes;

  bfa_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .sampleValid(sampleValid),
    .coefWrite  (coefWrite),
    .coefAddr   (coefAddr),
    .strobes    (strobes),
    .resultValid(resultValid)
  );

  bfa_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .sampleData(sampleData),
    .coefData  (coefData),
    .resultData(resultData)
  );
endmodule

// File: rtl/bfa_checker.sv
module bfa_checker #(
  parameter int ACC_W = 34
) (
  input logic             clk,
  input logic             rst,
  input logic             sampleValid,
  input logic             resultValid,
  input logic [ACC_W-1:0] resultData
);
  // R2: an accepted sample produces a valid output on the next cycle
  a_r2_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> resultValid);

  // R2 / R4: no accepted sample, no valid output
  a_r4_no_valid_in_gap: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> !resultValid);

  // R4: an idle edge leaves the output value untouched
  a_r4_hold_in_gap: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> $stable(resultData));

  // R8: reset clears the output stream
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!resultValid && resultData == '0));
endmodule

bind bcast_fir_array bfa_checker #(.ACC_W(2 * DATA_W + 2)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .sampleValid(sampleValid),
  .resultValid(resultValid),
  .resultData (resultData)
);

// File: tb/bcast_fir_array_tb.sv
`timescale 1ns/1ps
module bcast_fir_array_tb_top;
  localparam int DATA_W = 16;
  localparam int ACC_W  = 2 * DATA_W + 2;
  localparam int HIST   = 8192;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     sampleValid = 1'b0;
  logic signed [DATA_W-1:0] sampleData = '0;
  logic                     coefWrite = 1'b0;
  logic [1:0]               coefAddr = '0;
  logic signed [DATA_W-1:0] coefData = '0;
  logic                     resultValid;
  logic signed [ACC_W-1:0]  resultData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // bench model state: current coefficients and per-sample snapshots
  longint cw [3];
  longint xs [HIST];
  longint w0s [HIST];
  longint w1s [HIST];
  longint w2s [HIST];
  int     idx = 0;
  longint lastY = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;  // 125 MHz

  bcast_fir_array #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst),
    .sampleValid(sampleValid), .sampleData(sampleData),
    .coefWrite(coefWrite), .coefAddr(coefAddr), .coefData(coefData),
    .resultValid(resultValid), .resultData(resultData)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint expectAt(input int n);
    longint y = w0s[n] * xs[n];
    if (n >= 1) y += w1s[n-1] * xs[n-1];
    if (n >= 2) y += w2s[n-2] * xs[n-2];
    return y;
  endfunction

  // one cycle: optional sample and optional coefficient write at the same edge
  task automatic cyc(input bit v, input longint x, input bit we,
                     input int a, input longint cd, input string tag);
    longint y;
    @(negedge clk);
    sampleValid = v;
    sampleData  = DATA_W'(x);
    coefWrite   = we;
    coefAddr    = 2'(a);
    coefData    = DATA_W'(cd);
    @(posedge clk);
    if (v) begin
      // sample uses coefficients in force before this edge (R5)
      xs[idx] = x; w0s[idx] = cw[0]; w1s[idx] = cw[1]; w2s[idx] = cw[2];
    end
    if (we && a < 3) cw[a] = cd;  // code 3 has no target (R7)
    #1;
    if (v) begin
      y = expectAt(idx);
      idx++;
      check({tag, " valid"}, longint'(resultValid), 1);
      check({tag, " data"}, longint'(resultData), y);
      lastY = y;
    end else begin
      check({tag, " idle valid"}, longint'(resultValid), 0);
      check({tag, " idle hold"}, longint'(resultData), lastY);
    end
  endtask

  task automatic push(input longint x, input string tag);
    cyc(1, x, 0, 0, 0, tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input int a, input longint cd, input string tag);
    cyc(0, 0, 1, a, cd, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; sampleValid = 0; coefWrite = 0;
    @(posedge clk); @(posedge clk);
    #1;
    // R8: outputs cleared while reset is applied
    check("R8 reset valid", longint'(resultValid), 0);
    check("R8 reset data", longint'(resultData), 0);
    @(negedge clk);
    rst = 1'b0;
    cw[0] = 0; cw[1] = 0; cw[2] = 0;
    idx = 0; lastY = 0;
  endtask

  function automatic logic [15:0] nextLfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    doReset();

    // R8: coefficients cleared by reset -> impulse gives zero
    push(1000, "R8 cleared coef");
    push(0, "R8 cleared coef");

    doReset();
    // R1/R3: impulse shows each tap at its own lag
    wr(0, 3, "R5 load"); wr(1, -5, "R5 load"); wr(2, 7, "R5 load");
    push(1, "R3 impulse first");
    push(0, "R1 impulse"); push(0, "R1 impulse"); push(0, "R1 impulse");

    // R1: step
    for (int i = 0; i < 5; i++) push(100, "R1 step");

    // R7: write to code 3 leaves all taps untouched
    wr(3, 12345, "R7 ignored");
    push(0, "R7"); push(0, "R7");
    push(1, "R7 impulse"); push(0, "R7 impulse"); push(0, "R7 impulse");

    // R4: gapped stream
    push(11, "R4 gap"); idle("R4 gap"); idle("R4 gap");
    push(-22, "R4 gap"); idle("R4 gap"); push(33, "R4 gap");
    wr(3, 1, "R4 gap write"); push(44, "R4 gap");

    // R5/R6: mid-stream writes, including same-edge write
    cyc(1, 50, 1, 0, 9, "R5 same edge");
    push(60, "R5 after");
    cyc(1, -70, 1, 2, -4, "R6 midstream");
    cyc(1, 80, 1, 1, 2, "R6 midstream");
    push(90, "R6"); push(0, "R6"); push(0, "R6");

    // R9: full-scale negative operands
    doReset();
    wr(0, -32768, "R9 load"); wr(1, -32768, "R9 load"); wr(2, -32768, "R9 load");
    push(-32768, "R9"); push(-32768, "R9"); push(-32768, "R9");
    check("R9 full scale", longint'(resultData), longint'(3) <<< 30);
    push(32767, "R9 mixed"); push(-32768, "R9 mixed");

    // R1/R4/R6: pseudo-random sweep with gaps and occasional writes
    doReset();
    for (int s = 0; s < 12; s++) begin
      for (int t = 0; t < 3; t++) begin
        lfsr = nextLfsr(lfsr);
        wr(t, (s == 5) ? -32768 : longint'($signed(lfsr)), "R1 sweep load");
      end
      for (int i = 0; i < 400; i++) begin
        bit v;
        bit w;
        lfsr = nextLfsr(lfsr);
        v = (lfsr[3:0] != 4'h0);
        w = (lfsr[9:5] == 5'h1f);
        cyc(v, (s == 5) ? -32768 : longint'($signed(nextLfsr(lfsr))),
            w, int'(lfsr[12:11]), longint'($signed(lfsr ^ 16'h5a5a)), "R6 sweep");
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule